// File: doc/BRIEF.md
# LPI Pending Bit Update Controller

This block sits between the sources of message-based interrupt events and the memory-resident pending bitmap of one processor's redistributor. Each request names a single LPI ID and a level: a translated interrupt command asks to set the pending bit, while a clear or discard command, or the processor acknowledging an ID of 8192 or above, asks to clear it. The controller reads the byte that holds the bit, writes it back with only that bit changed when the bit actually has to change, and keeps a cached record of the best pending LPI up to date.

On a set, the configuration byte of the ID is fetched and its priority is compared with the cached best. The cache is replaced when the new one wins. On a clear of the ID that is the cached best, the controller cannot tell what the next best one is without looking at the whole bitmap. It raises a rescan request to an external scanner and loads the scanner's result when that scanner reports done. Requests are taken one at a time. Ready is high only while the controller is idle.

Top module: `lpi_pend_ctrl`

## Requirements
- R1: After reset the cached best priority is 0xFF and the cached best ID is 0, and `reqReady` is high. A request is taken on a clock edge with `reqValid` and `reqReady` both high. `reqReady` stays low from then until all memory traffic and any priority check or rescan handshake for that request has completed.
- R2: A request is dropped with no memory access and no change to the cache when any of these holds: `lpiEnable` is low, `pendBase` is zero, `cfgBase` is zero, the ID is below 8192, or the ID is above 2^(idBits+1) − 1.
- R3: The pending bit for an ID is bit (ID mod 8) of the byte at `pendBase` + ID/8. `memRdEn` returns that byte on `memRData` one cycle later.
- R4: When the stored bit already equals the requested level, no write is made and the cached best is left unchanged.
- R5: Otherwise the byte is written back to the same address with only the target bit changed and all other bits preserved.
- R6: After a set that changed the bit, the configuration byte at `cfgBase` + (ID − 8192) is read with one cycle of latency. Bit 0 of that byte is the enable bit, and a byte with bit 0 clear never changes the cache.
- R7: The priority of an enabled configuration byte C is C & 0xFC when `secDisable` is high. Otherwise it is ((C & 0xFC) >> 1) | 0x80.
- R8: An enabled set replaces the cache when its priority is lower than the cached priority, or when the priorities are equal and its ID is lower than or equal to the cached ID. Otherwise the cache holds its value.
- R9: A clear that changed the bit of the cached best ID raises `rescanReq`. It holds `rescanReq` until `rescanDone`, then loads `rescanBestId` and `rescanBestPrio` into the cache. A clear of any other ID raises no rescan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqId | input | ID_W | LPI ID of the request |
| reqLevel | input | 1 | 1 = set pending, 0 = clear pending |
| lpiEnable | input | 1 | LPI handling enabled for this redistributor |
| secDisable | input | 1 | Selects the single-security priority mapping |
| idBits | input | IDB_W | ID width field; highest valid ID is 2^(idBits+1) − 1 |
| pendBase | input | ADDR_W | Byte address of the pending bitmap |
| cfgBase | input | ADDR_W | Byte address of the configuration table |
| memRdEn | output | 1 | Pending byte read strobe |
| memWe | output | 1 | Pending byte write strobe |
| memAddr | output | ADDR_W | Pending byte address |
| memWData | output | 8 | Byte written back |
| memRData | input | 8 | Byte read, valid the cycle after memRdEn |
| cfgRdEn | output | 1 | Configuration byte read strobe |
| cfgAddr | output | ADDR_W | Configuration byte address |
| cfgRData | input | 8 | Configuration byte, valid the cycle after cfgRdEn |
| rescanReq | output | 1 | Full bitmap rescan requested |
| rescanDone | input | 1 | Rescan finished, result on the rescan inputs |
| rescanBestId | input | ID_W | Best ID found by the rescan |
| rescanBestPrio | input | 8 | Best priority found by the rescan (0xFF if none) |
| bestId | output | ID_W | Cached best pending LPI ID |
| bestPrio | output | 8 | Cached best pending LPI priority |

## Verification
The bench repeats sets and clears of IDs that are already in the requested state. A design that writes anyway, or that rescans on a redundant clear, shows up as extra write or rescan counts. It sets two IDs of equal priority in both orders, so a tie rule that compares strictly or in the wrong direction leaves the wrong ID cached. It tests each drop condition and the largest valid ID, which catch an off-by-one in the ID limit or a missing base check. With both priority mappings, and with a disabled configuration byte, it checks that a wrong remap or an ignored enable bit corrupts the cached priority.

// File: rtl/lpi_pend_pkg.sv
package lpi_pend_pkg;

  localparam logic [7:0] PRIO_FIELD_MASK = 8'hFC;
  localparam logic [7:0] PRIO_NONE       = 8'hFF;
  localparam int         CFG_EN_BIT      = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND_RD,
    ST_PEND_WB,
    ST_CFG_RD,
    ST_CFG_CHK,
    ST_RESCAN
  } lpiState_t;

  typedef struct packed {
    logic latchReq;
    logic pendRd;
    logic pendWr;
    logic cfgRd;
    logic cfgCheck;
    logic bestLoad;
  } lpiStrobes_t;

  // Map a configuration byte to the effective priority.
  function automatic logic [7:0] remapPrio(input logic [7:0] cfgByte, input logic secDis);
    logic [7:0] raw;
    raw = cfgByte & PRIO_FIELD_MASK;
    return secDis ? raw : ({1'b0, raw[7:1]} | 8'h80);
  endfunction

endpackage

// File: rtl/lpi_pend_dp.sv
module lpi_pend_dp
  import lpi_pend_pkg::*;
#(
  parameter int ID_W     = 16,
  parameter int ADDR_W   = 32,
  parameter int IDB_W    = 4,
  parameter int LPI_BASE = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpiStrobes_t       stb,
  input  logic [ID_W-1:0]   reqId,
  input  logic              reqLevel,
  input  logic              lpiEnable,
  input  logic              secDisable,
  input  logic [IDB_W-1:0]  idBits,
  input  logic [ADDR_W-1:0] pendBase,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [7:0]        memRData,
  input  logic [7:0]        cfgRData,
  input  logic [ID_W-1:0]   rescanBestId,
  input  logic [7:0]        rescanBestPrio,
  output logic              reqDrop,
  output logic              bitDiffers,
  output logic              hitBest,
  output logic              curLevel,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWData,
  output logic [ADDR_W-1:0] cfgAddr,
  output logic [ID_W-1:0]   bestId,
  output logic [7:0]        bestPrio
);

  localparam int SHIFT_W = IDB_W + 1;

  logic [ID_W-1:0]    curId;
  logic [SHIFT_W-1:0] limitShift;
  logic               tooWide;
  logic               belowBase;
  logic [7:0]         bitMask;
  logic [7:0]         candPrio;
  logic               candEn;
  logic               candWins;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curId    <= '0;
      curLevel <= 1'b0;
    end else if (stb.latchReq) begin
      curId    <= reqId;
      curLevel <= reqLevel;
    end
  end

  // Admission checks on the incoming request.
  assign limitShift = SHIFT_W'(idBits) + SHIFT_W'(1);
  assign tooWide    = (reqId >> limitShift) != '0;
  assign belowBase  = reqId < ID_W'(LPI_BASE);
  assign reqDrop    = !lpiEnable || (pendBase == '0) || (cfgBase == '0) || belowBase || tooWide;

  // Pending byte read-modify-write.
  assign memAddr    = pendBase + ADDR_W'(curId >> 3);
  assign bitMask    = 8'b1 << curId[2:0];
  assign bitDiffers = ((memRData & bitMask) != 8'h00) != curLevel;
  assign memWData   = curLevel ? (memRData | bitMask) : (memRData & ~bitMask);

  // Priority check against the cached best.
  assign cfgAddr  = cfgBase + ADDR_W'(curId - ID_W'(LPI_BASE));
  assign candEn   = cfgRData[CFG_EN_BIT];
  assign candPrio = remapPrio(cfgRData, secDisable);
  assign candWins = (candPrio < bestPrio) || ((candPrio == bestPrio) && (curId <= bestId));
  assign hitBest  = curId == bestId;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestId   <= '0;
      bestPrio <= PRIO_NONE;
    end else if (stb.bestLoad) begin
      bestId   <= rescanBestId;
      bestPrio <= rescanBestPrio;
    end else if (stb.cfgCheck && candEn && candWins) begin
      bestId   <= curId;
      bestPrio <= candPrio;
    end
  end

endmodule

// File: rtl/lpi_pend_fsm.sv
module lpi_pend_fsm
  import lpi_pend_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqDrop,
  input  logic        bitDiffers,
  input  logic        curLevel,
  input  logic        hitBest,
  input  logic        rescanDone,
  output logic        reqReady,
  output logic        rescanReq,
  output lpiStrobes_t stb
);

  lpiState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    reqReady  = 1'b0;
    rescanReq = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.latchReq = 1'b1;
          if (!reqDrop) nextState = ST_PEND_RD;
        end
      end
      ST_PEND_RD: begin
        stb.pendRd = 1'b1;
        nextState  = ST_PEND_WB;
      end
      ST_PEND_WB: begin
        if (bitDiffers) begin
          stb.pendWr = 1'b1;
          if (curLevel)     nextState = ST_CFG_RD;
          else if (hitBest) nextState = ST_RESCAN;
          else              nextState = ST_IDLE;
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_CFG_RD: begin
        stb.cfgRd = 1'b1;
        nextState = ST_CFG_CHK;
      end
      ST_CFG_CHK: begin
        stb.cfgCheck = 1'b1;
        nextState    = ST_IDLE;
      end
      ST_RESCAN: begin
        rescanReq = 1'b1;
        if (rescanDone) begin
          stb.bestLoad = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/lpi_pend_ctrl.sv
module lpi_pend_ctrl
  import lpi_pend_pkg::*;
#(
  parameter int ID_W     = 16,
  parameter int ADDR_W   = 32,
  parameter int IDB_W    = 4,
  parameter int LPI_BASE = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ID_W-1:0]   reqId,
  input  logic              reqLevel,
  input  logic              lpiEnable,
  input  logic              secDisable,
  input  logic [IDB_W-1:0]  idBits,
  input  logic [ADDR_W-1:0] pendBase,
  input  logic [ADDR_W-1:0] cfgBase,
  output logic              memRdEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWData,
  input  logic [7:0]        memRData,
  output logic              cfgRdEn,
  output logic [ADDR_W-1:0] cfgAddr,
  input  logic [7:0]        cfgRData,
  output logic              rescanReq,
  input  logic              rescanDone,
  input  logic [ID_W-1:0]   rescanBestId,
  input  logic [7:0]        rescanBestPrio,
  output logic [ID_W-1:0]   bestId,
  output logic [7:0]        bestPrio
);

  lpiStrobes_t stb;
  logic reqDrop, bitDiffers, hitBest, curLevel;

  lpi_pend_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqDrop    (reqDrop),
    .bitDiffers (bitDiffers),
    .curLevel   (curLevel),
    .hitBest    (hitBest),
    .rescanDone (rescanDone),
    .reqReady   (reqReady),
    .rescanReq  (rescanReq),
    .stb        (stb)
  );

  lpi_pend_dp #(
    .ID_W     (ID_W),
    .ADDR_W   (ADDR_W),
    .IDB_W    (IDB_W),
    .LPI_BASE (LPI_BASE)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .reqId          (reqId),
    .reqLevel       (reqLevel),
    .lpiEnable      (lpiEnable),
    .secDisable     (secDisable),
    .idBits         (idBits),
    .pendBase       (pendBase),
    .cfgBase        (cfgBase),
    .memRData       (memRData),
    .cfgRData       (cfgRData),
    .rescanBestId   (rescanBestId),
    .rescanBestPrio (rescanBestPrio),
    .reqDrop        (reqDrop),
    .bitDiffers     (bitDiffers),
    .hitBest        (hitBest),
    .curLevel       (curLevel),
    .memAddr        (memAddr),
    .memWData       (memWData),
    .cfgAddr        (cfgAddr),
    .bestId         (bestId),
    .bestPrio       (bestPrio)
  );

  assign memRdEn = stb.pendRd;
  assign memWe   = stb.pendWr;
  assign cfgRdEn = stb.cfgRd;

endmodule

// File: rtl/lpi_pend_checker.sv
module lpi_pend_checker #(
  parameter int ID_W   = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              lpiEnable,
  input logic              memRdEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memWData,
  input logic [7:0]        memRData,
  input logic              cfgRdEn,
  input logic              rescanReq,
  input logic              rescanDone,
  input logic [ID_W-1:0]   bestId,
  input logic [7:0]        bestPrio
);

  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWe || cfgRdEn || rescanReq) |-> !reqReady);

  p_drop_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !lpiEnable) |=> !memRdEn);

  p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($past(memRdEn) && $stable(memAddr)));

  p_single_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($countones(memWData ^ memRData) == 1));

  p_cfg_after_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdEn |-> $past(memWe && ($countones(memWData) > $countones(memRData))));

  p_cache_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(bestPrio) || !$stable(bestId)) |-> ($past(cfgRdEn, 2) || $past(rescanDone && rescanReq)));

  p_cache_no_worse_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgRdEn, 2) && !$stable(bestPrio)) |-> (bestPrio < $past(bestPrio)));

  p_rescan_after_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rescanReq) |-> $past(memWe && ($countones(memWData) < $countones(memRData))));

endmodule

bind lpi_pend_ctrl lpi_pend_checker #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .lpiEnable  (lpiEnable),
  .memRdEn    (memRdEn),
  .memWe      (memWe),
  .memAddr    (memAddr),
  .memWData   (memWData),
  .memRData   (memRData),
  .cfgRdEn    (cfgRdEn),
  .rescanReq  (rescanReq),
  .rescanDone (rescanDone),
  .bestId     (bestId),
  .bestPrio   (bestPrio)
);

// File: tb/lpi_pend_ctrl_bench.sv
`timescale 1ns/1ps
module lpi_pend_ctrl_bench;

  localparam int ID_W = 16;
  localparam int ADDR_W = 32;
  localparam int IDB_W = 4;
  localparam logic [31:0] PEND_BASE = 32'h0000_1000;
  localparam logic [31:0] CFG_BASE  = 32'h0000_2000;

  typedef struct packed {
    logic [15:0] id;
    logic        lvl;
    logic [7:0]  byteV;
    logic [15:0] bId;
    logic [7:0]  bPrio;
    logic [7:0]  wr;
    logic [7:0]  rs;
  } vec_t;

  // Cumulative write and rescan counts; byteV is the byte covering IDs 8192..8199.
  localparam vec_t VECS [10] = '{
    '{16'd8193, 1'b1, 8'h02, 16'd8193, 8'h20, 8'd1, 8'd0},
    '{16'd8193, 1'b1, 8'h02, 16'd8193, 8'h20, 8'd1, 8'd0},
    '{16'd8192, 1'b1, 8'h03, 16'd8193, 8'h20, 8'd2, 8'd0},
    '{16'd8194, 1'b1, 8'h07, 16'd8193, 8'h20, 8'd3, 8'd0},
    '{16'd8195, 1'b1, 8'h0F, 16'd8193, 8'h20, 8'd4, 8'd0},
    '{16'd8192, 1'b0, 8'h0E, 16'd8193, 8'h20, 8'd5, 8'd0},
    '{16'd8193, 1'b0, 8'h0C, 16'd8194, 8'h20, 8'd6, 8'd1},
    '{16'd8193, 1'b0, 8'h0C, 16'd8194, 8'h20, 8'd6, 8'd1},
    '{16'd8193, 1'b1, 8'h0E, 16'd8193, 8'h20, 8'd7, 8'd1},
    '{16'd8197, 1'b1, 8'h2E, 16'd8193, 8'h20, 8'd8, 8'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady, reqLevel = 1'b0;
  logic [ID_W-1:0] reqId = '0;
  logic lpiEnable = 1'b1, secDisable = 1'b1;
  logic [IDB_W-1:0] idBits = 4'd13;
  logic [ADDR_W-1:0] pendBase = PEND_BASE, cfgBase = CFG_BASE;
  logic memRdEn, memWe, cfgRdEn, rescanReq;
  logic [ADDR_W-1:0] memAddr, cfgAddr;
  logic [7:0] memWData, memRData = 8'h00, cfgRData = 8'h00;
  logic rescanDone = 1'b0;
  logic [ID_W-1:0] rescanBestId = '0, bestId;
  logic [7:0] rescanBestPrio = 8'hFF, bestPrio;

  logic [7:0] pendMem [4096];
  logic [7:0] cfgMem [256];
  int wrCount = 0, rsCount = 0, checks = 0, fails = 0;
  logic [ADDR_W-1:0] lastCfgAddr = '0;

  always #10 clk = ~clk;

  lpi_pend_ctrl u_lpi_pend_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqId(reqId), .reqLevel(reqLevel), .lpiEnable(lpiEnable),
    .secDisable(secDisable), .idBits(idBits), .pendBase(pendBase),
    .cfgBase(cfgBase), .memRdEn(memRdEn), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData), .cfgRdEn(cfgRdEn),
    .cfgAddr(cfgAddr), .cfgRData(cfgRData), .rescanReq(rescanReq),
    .rescanDone(rescanDone), .rescanBestId(rescanBestId),
    .rescanBestPrio(rescanBestPrio), .bestId(bestId), .bestPrio(bestPrio)
  );

  always @(posedge clk) begin
    if (memRdEn) memRData <= pendMem[memAddr[11:0]];
    if (memWe) begin
      pendMem[memAddr[11:0]] <= memWData;
      wrCount <= wrCount + 1;
    end
    if (cfgRdEn) begin
      cfgRData    <= cfgMem[8'(cfgAddr - cfgBase)];
      lastCfgAddr <= cfgAddr;
    end
  end

  // External scanner model over IDs 8192..8255.
  initial begin
    forever begin
      @(negedge clk);
      if (rescanReq) begin
        logic [7:0] bp;
        logic [15:0] bi;
        bp = 8'hFF;
        bi = 16'd0;
        for (int k = 0; k < 64; k++) begin
          logic [7:0] c, p;
          c = cfgMem[k];
          if (pendMem[12'h400 + 12'(k / 8)][k % 8] && c[0]) begin
            p = secDisable ? (c & 8'hFC) : (8'h80 | ((c >> 1) & 8'h7E));
            if (p < bp || (p == bp && 16'(8192 + k) <= bi)) begin
              bp = p;
              bi = 16'(8192 + k);
            end
          end
        end
        rescanBestId = bi;
        rescanBestPrio = bp;
        rescanDone = 1'b1;
        @(negedge clk);
        rescanDone = 1'b0;
        rsCount++;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic doReq(input logic [15:0] id, input logic lvl);
    @(negedge clk);
    reqId = id;
    reqLevel = lvl;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clearMem();
    for (int i = 0; i < 4096; i++) pendMem[i] = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=idle");
    finishRun();
  end

  initial begin
    int w0, r0;
    clearMem();
    for (int i = 0; i < 256; i++) cfgMem[i] = 8'h00;
    cfgMem[0] = 8'h41; cfgMem[1] = 8'h21; cfgMem[2] = 8'h21;
    cfgMem[3] = 8'h20; cfgMem[5] = 8'h41;
    repeat (3) @(negedge clk);
    check("R1 reset bestPrio", 32'(bestPrio), 32'hFF);
    check("R1 reset bestId", 32'(bestId), 32'h0);
    check("R1 reset ready", 32'(reqReady), 32'h1);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 10; v++) begin
      doReq(VECS[v].id, VECS[v].lvl);
      check($sformatf("R3 R5 vec%0d byte", v), 32'(pendMem[12'h400]), 32'(VECS[v].byteV));
      check($sformatf("R4 vec%0d writes", v), wrCount, 32'(VECS[v].wr));
      check($sformatf("R8 vec%0d bestId", v), 32'(bestId), 32'(VECS[v].bId));
      check($sformatf("R8 vec%0d bestPrio", v), 32'(bestPrio), 32'(VECS[v].bPrio));
      check($sformatf("R9 vec%0d rescans", v), rsCount, 32'(VECS[v].rs));
    end

    // R2: drop conditions
    w0 = wrCount;
    lpiEnable = 1'b0; doReq(16'd8196, 1'b1); lpiEnable = 1'b1;
    check("R2 lpi disabled writes", wrCount, w0);
    pendBase = '0; doReq(16'd8196, 1'b1); pendBase = PEND_BASE;
    check("R2 pend base zero writes", wrCount, w0);
    cfgBase = '0; doReq(16'd8196, 1'b1); cfgBase = CFG_BASE;
    check("R2 cfg base zero writes", wrCount, w0);
    check("R2 byte untouched", 32'(pendMem[12'h400]), 32'h2E);
    doReq(16'd8191, 1'b1);
    check("R2 below 8192 writes", wrCount, w0);
    check("R2 below 8192 byte", 32'(pendMem[12'h3FF]), 32'h0);
    doReq(16'd16384, 1'b1);
    check("R2 above limit writes", wrCount, w0);
    doReq(16'd16383, 1'b1);
    check("R2 top id accepted", wrCount, w0 + 1);
    check("R3 top id byte", 32'(pendMem[12'h7FF]), 32'h80);
    check("R6 cfg address", lastCfgAddr, CFG_BASE + 32'd8191);
    check("R6 disabled cfg keeps bestId", 32'(bestId), 32'd8193);
    check("R6 disabled cfg keeps bestPrio", 32'(bestPrio), 32'h20);
    check("R1 ready after request", 32'(reqReady), 32'h1);

    // R7: remapped priorities after a fresh reset
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R1 reset again bestPrio", 32'(bestPrio), 32'hFF);
    clearMem();
    rstN = 1'b1;
    secDisable = 1'b0;
    cfgMem[6] = 8'h11; cfgMem[7] = 8'h15; cfgMem[4] = 8'h0D;
    doReq(16'd8198, 1'b1);
    check("R7 remap bestPrio", 32'(bestPrio), 32'h88);
    check("R7 remap bestId", 32'(bestId), 32'd8198);
    doReq(16'd8199, 1'b1);
    check("R7 R8 worse kept", 32'(bestId), 32'd8198);
    doReq(16'd8196, 1'b1);
    check("R7 better prio", 32'(bestPrio), 32'h86);
    check("R7 better id", 32'(bestId), 32'd8196);
    r0 = rsCount;
    doReq(16'd8198, 1'b0);
    check("R9 clear non-best no rescan", rsCount, r0);
    check("R9 clear non-best keeps best", 32'(bestId), 32'd8196);
    doReq(16'd8196, 1'b0);
    check("R9 clear best rescans", rsCount, r0 + 1);
    check("R9 rescan bestId", 32'(bestId), 32'd8199);
    check("R9 rescan bestPrio", 32'(bestPrio), 32'h8A);
    finishRun();
  end

endmodule